// File: doc/BRIEF.md
# Staged Elementary Cellular Automaton Engine

This block keeps a ring of binary cells and advances it by a chosen number of generations under an 8-bit rule number. The rule is given at run time, and every value from 0 to 255 is supported. Each cell holds two bits. The primary bit is the visible state. The shadow bit is a frozen copy of that state taken at the start of the generation.

A generation is not computed in one combinational step. It runs as a series of separate phases:
- A raise stage acts only on cells that were 0.
- A clear stage acts only on cells that were 1.
- A copy phase then refreshes the shadows.

Both stages read the neighbourhood from the shadow bits, so an update made earlier in the same generation never affects a neighbour. For some rule subsets the raise or the clear condition is a parity of the two neighbours. A parity cannot be decided in one threshold-style step, so the block spends two consecutive steps on that stage.

To use the block, load an initial vector while it is idle, present the rule and a generation count, and pulse start. `busy_o` stays high while the engine runs. `done_o` pulses once when the last generation has been committed. `rule_i` must be held steady during a run.

Top module: `eca_stage_engine`

## Requirements
- R1: Cell index CELLS-1 is the leftmost cell and index 0 the rightmost; cell i has left neighbour i+1 and right neighbour i-1. After one generation, cell i equals rule bit number 4*left + 2*centre + right of the previous generation.
- R2: The ring wraps: the left neighbour of cell CELLS-1 is cell 0, and the right neighbour of cell 0 is cell CELLS-1.
- R3: While idle, `load_i` writes `load_state_i` into both the primary and shadow bits, visible on `cells_o` the next cycle; while busy, `load_i` has no effect.
- R4: The raise stage changes only cells that were 0 at the start of the generation, and sets them according to rule bits 5, 4, 1 and 0.
- R5: The clear stage changes only cells that were 1 at the start of the generation, and keeps them according to rule bits 7, 6, 3 and 2.
- R6: Neighbour values come from the shadow bits, which change only during the copy phase (or on load).
- R7: A generation lasts 3 cycles. It gains one extra cycle when {rule[5],rule[4],rule[1],rule[0]} is 0110 or 1001, and one more when {rule[7],rule[6],rule[3],rule[2]} is 0110 or 1001.
- R8: `busy_o` is high from the cycle after an accepted start until the cycle `done_o` rises; a start while busy is ignored.
- R9: `done_o` is a one-cycle pulse after the final copy phase. A start with a count of 0 pulses `done_o` the next cycle, leaves the cells unchanged and keeps `busy_o` low.
- R10: After reset, `cells_o`, `busy_o` and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rule_i | input | 8 | Rule number, held during a run |
| load_i | input | 1 | Load initial vector (idle only) |
| load_state_i | input | CELLS | Initial cell vector |
| start_i | input | 1 | Begin a run |
| gen_count_i | input | GEN_W | Number of generations to run |
| cells_o | output | CELLS | Primary cell bits |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Rules 30, 54, 94, 110, 118, 116, 171 and 190 are each run for 15 generations from a single centred seed, against a behavioural one-step evaluation. Rules 30 (two-step raise) and 105 (two-step raise and clear) separate the stretched phase timings from the plain 3-cycle timing. Rules 2 and 16 shift a lone bit sitting at either end of the ring, which shows the wrap in each direction. Rules 0 and 255 and a dense random-looking seed under rule 110 show that raise-only and clear-only cases are kept apart. A zero count, and a load and start injected mid-run, cover the ignore paths.

// File: rtl/eca_pkg.sv
package eca_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SET1 = 3'd1,
    PH_SET2 = 3'd2,
    PH_RST1 = 3'd3,
    PH_RST2 = 3'd4,
    PH_COPY = 3'd5
  } phase_e;

  // Raise-condition nibble indexed by {left, right} for centre = 0
  function automatic logic [3:0] raise_nibble(input logic [7:0] rule);
    return {rule[5], rule[4], rule[1], rule[0]};
  endfunction

  // Keep-condition nibble indexed by {left, right} for centre = 1
  function automatic logic [3:0] keep_nibble(input logic [7:0] rule);
    return {rule[7], rule[6], rule[3], rule[2]};
  endfunction

  // Parity-shaped subsets need two steps
  function automatic logic is_parity(input logic [3:0] nib);
    return (nib == 4'b0110) || (nib == 4'b1001);
  endfunction

endpackage

// File: rtl/eca_phase_ctrl.sv
module eca_phase_ctrl
  import eca_pkg::*;
#(
  parameter int GEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rule_i,
  input  logic             start_i,
  input  logic [GEN_W-1:0] gen_count_i,
  output logic             idle_o,
  output logic [3:0]       set_mask_o,
  output logic [3:0]       clr_mask_o,
  output logic             copy_en_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [GEN_W-1:0] LAST_GEN = GEN_W'(1);

  phase_e           phase_q;
  logic [GEN_W-1:0] gen_q;
  logic             done_q;

  logic [3:0] raise_n, clear_n;
  logic       two_set, two_rst;

  assign raise_n = raise_nibble(rule_i);
  assign clear_n = ~keep_nibble(rule_i);
  assign two_set = is_parity(raise_n);
  assign two_rst = is_parity(clear_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      gen_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            if (gen_count_i == '0) begin
              done_q <= 1'b1;
            end else begin
              gen_q   <= gen_count_i;
              phase_q <= PH_SET1;
            end
          end
        end
        PH_SET1: phase_q <= two_set ? PH_SET2 : PH_RST1;
        PH_SET2: phase_q <= PH_RST1;
        PH_RST1: phase_q <= two_rst ? PH_RST2 : PH_COPY;
        PH_RST2: phase_q <= PH_COPY;
        PH_COPY: begin
          gen_q <= gen_q - 1'b1;
          if (gen_q == LAST_GEN) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            phase_q <= PH_SET1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    set_mask_o = 4'b0000;
    clr_mask_o = 4'b0000;
    unique case (phase_q)
      PH_SET1: set_mask_o = two_set ? (raise_n & 4'b0011) : raise_n;
      PH_SET2: set_mask_o = raise_n & 4'b1100;
      PH_RST1: clr_mask_o = two_rst ? (clear_n & 4'b0011) : clear_n;
      PH_RST2: clr_mask_o = clear_n & 4'b1100;
      default: ;
    endcase
  end

  assign idle_o    = (phase_q == PH_IDLE);
  assign copy_en_o = (phase_q == PH_COPY);
  assign busy_o    = !idle_o;
  assign done_o    = done_q;

  // R7: parity raise subset forces a second raise step
  a_r7_second_raise_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SET1 && two_set) |=> (phase_q == PH_SET2));

  // R7: a non-final copy starts the next generation at once
  a_r7_copy_then_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_COPY && gen_q != LAST_GEN) |=> (phase_q == PH_SET1));

  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: busy only drops together with done
  a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R9: done never overlaps busy
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: rtl/eca_cell.sv
module eca_cell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  logic       load_bit,
  input  logic [3:0] set_mask,
  input  logic [3:0] clr_mask,
  input  logic       copy_en,
  input  logic       left_sh,
  input  logic       right_sh,
  output logic       main_q,
  output logic       shadow_q
);

  logic [1:0] nbr_idx;
  assign nbr_idx = {left_sh, right_sh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q   <= 1'b0;
      shadow_q <= 1'b0;
    end else if (load_en) begin
      main_q   <= load_bit;
      shadow_q <= load_bit;
    end else begin
      if (!shadow_q && set_mask[nbr_idx]) main_q <= 1'b1;
      if (shadow_q && clr_mask[nbr_idx])  main_q <= 1'b0;
      if (copy_en)                        shadow_q <= main_q;
    end
  end

  // R4: raise steps leave cells that began the generation at 1 alone
  a_r4_raise_spares_ones: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_mask) && !load_en && shadow_q) |=> $stable(main_q));

  // R5: clear steps leave cells that began the generation at 0 alone
  a_r5_clear_spares_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_mask) && !load_en && !shadow_q) |=> $stable(main_q));

  // R6: shadow moves only on copy or load
  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy_en && !load_en) |=> $stable(shadow_q));

endmodule

// File: rtl/eca_stage_engine.sv
module eca_stage_engine
  import eca_pkg::*;
#(
  parameter int CELLS = 16,
  parameter int GEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rule_i,
  input  logic             load_i,
  input  logic [CELLS-1:0] load_state_i,
  input  logic             start_i,
  input  logic [GEN_W-1:0] gen_count_i,
  output logic [CELLS-1:0] cells_o,
  output logic             busy_o,
  output logic             done_o
);

  logic             idle, copy_en, load_en;
  logic [3:0]       set_mask, clr_mask;
  logic [CELLS-1:0] main_v, shadow_v;

  assign load_en = load_i && idle;

  eca_phase_ctrl #(.GEN_W(GEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rule_i      (rule_i),
    .start_i     (start_i),
    .gen_count_i (gen_count_i),
    .idle_o      (idle),
    .set_mask_o  (set_mask),
    .clr_mask_o  (clr_mask),
    .copy_en_o   (copy_en),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_ring
    localparam int LEFT  = (i + 1) % CELLS;
    localparam int RIGHT = (i + CELLS - 1) % CELLS;
    eca_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_en),
      .load_bit (load_state_i[i]),
      .set_mask (set_mask),
      .clr_mask (clr_mask),
      .copy_en  (copy_en),
      .left_sh  (shadow_v[LEFT]),
      .right_sh (shadow_v[RIGHT]),
      .main_q   (main_v[i]),
      .shadow_q (shadow_v[i])
    );
  end

  assign cells_o = main_v;

  // R3: a load while busy leaves the visible state unchanged
  a_r3_load_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !idle && !copy_en && set_mask == 4'b0 && clr_mask == 4'b0)
      |=> $stable(cells_o));

endmodule

// File: tb/tb_eca_stage_engine.sv
module tb_eca_stage_engine;
  localparam int N = 16;
  localparam int GW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    rule_i = '0;
  logic          load_i = 1'b0;
  logic [N-1:0]  load_state_i = '0;
  logic          start_i = 1'b0;
  logic [GW-1:0] gen_count_i = '0;
  logic [N-1:0]  cells_o;
  logic          busy_o, done_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  eca_stage_engine #(.CELLS(N), .GEN_W(GW)) dut (
    .clk(clk), .rst_n(rst_n), .rule_i(rule_i), .load_i(load_i),
    .load_state_i(load_state_i), .start_i(start_i), .gen_count_i(gen_count_i),
    .cells_o(cells_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic [N-1:0] ref_next(input logic [7:0] rl, input logic [N-1:0] v);
    logic [N-1:0] o;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = 4 * int'(v[(i + 1) % N]) + 2 * int'(v[i]) + int'(v[(i + N - 1) % N]);
      o[i] = rl[idx];
    end
    return o;
  endfunction

  function automatic int gen_cycles(input logic [7:0] rl);
    int k;
    int a, b;
    k = 3;
    a = rl[5] * 8 + rl[4] * 4 + rl[1] * 2 + rl[0];
    b = (1 - rl[7]) * 8 + (1 - rl[6]) * 4 + (1 - rl[3]) * 2 + (1 - rl[2]);
    if (a == 6 || a == 9) k++;
    if (b == 6 || b == 9) k++;
    return k;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [N-1:0] v);
    @(negedge clk);
    load_i = 1'b1;
    load_state_i = v;
    @(negedge clk);
    load_i = 1'b0;
    check("R3 load", 32'(cells_o), 32'(v));
  endtask

  // inject: 1 = load and start pulses during first generation
  task automatic run_case(input string name, input logic [7:0] rl, input logic [N-1:0] init,
                          input int gens, input bit inject);
    logic [N-1:0] exp;
    int pg;
    rule_i = rl;
    do_load(init);
    exp = init;
    pg = gen_cycles(rl);
    gen_count_i = GW'(gens);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int g = 0; g < gens; g++) begin
      for (int c = 1; c <= pg; c++) begin
        bit last;
        @(negedge clk);
        last = (g == gens - 1) && (c == pg);
        if (inject && g == 0 && c == 1) begin
          load_i = 1'b1; load_state_i = ~init; start_i = 1'b1; gen_count_i = GW'(1);
        end
        if (inject && g == 0 && c == 2) begin
          load_i = 1'b0; start_i = 1'b0;
        end
        check("R8 busy", 32'(busy_o), 32'(!last));
        check("R9 done", 32'(done_o), 32'(last));
      end
      exp = ref_next(rl, exp);
      check({"R1 R2 R4 R5 R6 R7 gen ", name}, 32'(cells_o), 32'(exp));
    end
    @(negedge clk);
    check("R9 done single", 32'(done_o), 32'd0);
    check("R3 R8 idle after run", 32'(busy_o), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 cells", 32'(cells_o), 32'd0);
    check("R10 busy", 32'(busy_o), 32'd0);
    check("R10 done", 32'(done_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_case("rule30",  8'd30,  16'h0100, 15, 0);
    run_case("rule54",  8'd54,  16'h0100, 15, 0);
    run_case("rule94",  8'd94,  16'h0100, 15, 0);
    run_case("rule110", 8'd110, 16'h0100, 15, 0);
    run_case("rule118", 8'd118, 16'h0100, 15, 0);
    run_case("rule171", 8'd171, 16'h0100, 15, 0);
    run_case("rule116", 8'd116, 16'h0100, 15, 0);
    run_case("rule190", 8'd190, 16'h0100, 15, 0);
    run_case("rule105", 8'd105, 16'h0100, 6, 0);
    run_case("rule72",  8'd72,  16'h6666, 3, 0);
    run_case("R2 wrap left",  8'd2,  16'h8000, 2, 0);
    run_case("R2 wrap right", 8'd16, 16'h0001, 2, 0);
    run_case("rule0",   8'd0,   16'hF0F0, 1, 0);
    run_case("rule255", 8'd255, 16'h0F0F, 1, 0);
    run_case("dense110", 8'd110, 16'hA5C3, 10, 0);
    run_case("R3 R8 inject", 8'd30, 16'h0100, 4, 1);

    // R9: zero generation count
    rule_i = 8'd30;
    do_load(16'h1234);
    gen_count_i = '0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R9 zero count done", 32'(done_o), 32'd1);
    check("R9 zero count busy", 32'(busy_o), 32'd0);
    check("R9 zero count cells", 32'(cells_o), 32'h1234);
    @(negedge clk);
    check("R9 zero count pulse end", 32'(done_o), 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule